// File: doc/BRIEF.md
# Instruction-Steered Multiply-Add Unit

This block is a compact arithmetic slice whose operation is picked afresh on every clock by a 3-bit instruction. It holds an 8x8 multiplier, a 17-bit adder, a 16-bit accumulator and a result register. Two byte operands feed the multiplier, and a halfword operand feeds the adder. A sign control makes the whole datapath work either in two's complement or in unsigned arithmetic. The result leaves on a 17-bit bus whose top bit is the carry in unsigned work and the true sign in signed work.

An outside sequencer drives the instruction bus. It might be a queue of stored instructions or a small state machine. Because no instruction needs a setup cycle, a filter can switch between multiply, add, multiply-add and accumulate from one clock to the next. The low two instruction bits pick the operation. The top bit asks for the result to be held in the output register and shown during the following cycle.

Top module: `dyn_muladd`

## Requirements
- R1: The product is the 8x8 product of `mx` and `my`: unsigned when `sgn`=0 and two's complement when `sgn`=1. With `op[1:0]`=00, `res` is that product, zero-extended or sign-extended to 17 bits.
- R2: Every result is the sum of two 16-bit operands, taken modulo 2^17. When `sgn`=0 both operands are zero-extended, so `res[16]` is the unsigned carry-out. When `sgn`=1 both operands are sign-extended, so `res` is the exact signed sum.
- R3: With `op[1:0]`=01, `res` = `ad` + {`mx`,`my`}, with `mx` as the upper byte.
- R4: With `op[1:0]`=10, `res` = product + `ad`.
- R5: With `op[1:0]`=11, `res` = product + accumulator. The accumulator then loads `res[15:0]`, so it wraps modulo 2^16.
- R6: Instructions with `op[1:0]` other than 11 leave the accumulator unchanged.
- R7: `clr`=1 zeroes the accumulator at the next clock edge and takes precedence over an accumulate. The result shown in that cycle still uses the old accumulator value.
- R8: When `op[2]`=0 and the previous instruction had `op[2]`=0, `res` shows the current cycle's result combinationally.
- R9: When `op[2]`=1, the result is captured at the clock edge. It is shown on `res` for the whole next cycle, whatever instruction is present then. Back-to-back instructions of any mode need no idle cycle.
- R10: After reset the accumulator is zero and no result is held, so `res` follows the current inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous accumulator clear |
| op | input | 3 | Instruction: bits 1:0 select the operation, bit 2 selects a registered result |
| sgn | input | 1 | 1 = signed arithmetic, 0 = unsigned |
| mx | input | 8 | Multiplier operand, upper byte of the add operand |
| my | input | 8 | Multiplier operand, lower byte of the add operand |
| ad | input | 16 | Adder operand |
| res | output | 17 | Result including carry or sign bit |

## Verification
The hardest behaviour to observe is the interaction of state with the instruction stream: a registered result hiding the combinational result of the next instruction, and a clear that arrives together with an accumulate. The accumulator itself has no port. The stimulus therefore reads it back by issuing an accumulate with a zero multiplier operand, which shows the accumulator on `res`. It builds wrap-around states by accumulating large unsigned and negative signed products. Instruction pairs that switch between registered and combinational modes on consecutive cycles expose which result is on the bus in each cycle.

// File: rtl/dyn_muladd_pkg.sv
package dyn_muladd_pkg;

    typedef enum logic [1:0] {
        MD_MUL    = 2'b00,
        MD_ADD    = 2'b01,
        MD_MULADD = 2'b10,
        MD_MAC    = 2'b11
    } mode_e;

    function automatic mode_e decode_mode(input logic [2:0] instr);
        return mode_e'(instr[1:0]);
    endfunction

    function automatic logic wants_hold(input logic [2:0] instr);
        return instr[2];
    endfunction

endpackage

// File: rtl/dma_mult.sv
module dma_mult #(
    parameter int OPW = 8,
    localparam int PW = 2 * OPW
) (
    input  logic           sgn,
    input  logic [OPW-1:0] fa,
    input  logic [OPW-1:0] fb,
    output logic [PW-1:0]  prod
);
    logic signed [OPW:0]   fa_x;
    logic signed [OPW:0]   fb_x;
    logic signed [2*OPW+1:0] full;

    always_comb begin
        fa_x = $signed({sgn & fa[OPW-1], fa});
        fb_x = $signed({sgn & fb[OPW-1], fb});
        full = fa_x * fb_x;
        prod = full[PW-1:0];
    end
endmodule

// File: rtl/dma_adder.sv
module dma_adder #(
    parameter int AW = 16,
    localparam int SW = AW + 1
) (
    input  logic          sgn,
    input  logic [AW-1:0] lhs,
    input  logic [AW-1:0] rhs,
    output logic [SW-1:0] sum
);
    logic [SW-1:0] lhs_x;
    logic [SW-1:0] rhs_x;

    always_comb begin
        lhs_x = {sgn & lhs[AW-1], lhs};
        rhs_x = {sgn & rhs[AW-1], rhs};
        sum   = lhs_x + rhs_x;
    end
endmodule

// File: rtl/dyn_muladd.sv
module dyn_muladd
    import dyn_muladd_pkg::*;
#(
    parameter int OPW = 8,
    localparam int AW = 2 * OPW,
    localparam int RW = AW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [2:0]     op,
    input  logic           sgn,
    input  logic [OPW-1:0] mx,
    input  logic [OPW-1:0] my,
    input  logic [AW-1:0]  ad,
    output logic [RW-1:0]  res
);
    typedef struct packed {
        logic [AW-1:0] acc;
        logic [RW-1:0] hold;
        logic          sel;
    } state_t;

    state_t        st_d;
    state_t        st_q;
    mode_e         mode;
    logic [AW-1:0] prod;
    logic [AW-1:0] lhs;
    logic [AW-1:0] rhs;
    logic [RW-1:0] sum;
    logic [AW-1:0] acc_cur;
    logic          sel_cur;

    dma_mult #(.OPW(OPW)) mult_i (
        .sgn  (sgn),
        .fa   (mx),
        .fb   (my),
        .prod (prod)
    );

    dma_adder #(.AW(AW)) add_i (
        .sgn (sgn),
        .lhs (lhs),
        .rhs (rhs),
        .sum (sum)
    );

    // operand steering
    always_comb begin
        mode = decode_mode(op);
        lhs  = (mode == MD_ADD) ? {mx, my} : prod;
        unique case (mode)
            MD_MUL:    rhs = '0;
            MD_ADD:    rhs = ad;
            MD_MULADD: rhs = ad;
            MD_MAC:    rhs = st_q.acc;
            default:   rhs = '0;
        endcase
    end

    // next state
    always_comb begin
        st_d      = st_q;
        st_d.sel  = wants_hold(op);
        st_d.hold = sum;
        if (clr) begin
            st_d.acc = '0;
        end else if (mode == MD_MAC) begin
            st_d.acc = sum[AW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res     = st_q.sel ? st_q.hold : sum;
    assign acc_cur = st_q.acc;
    assign sel_cur = st_q.sel;
endmodule

// File: rtl/dyn_muladd_chk.sv
module dyn_muladd_chk #(
    parameter int OPW = 8,
    localparam int AW = 2 * OPW,
    localparam int RW = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic [2:0]    op,
    input logic          sgn,
    input logic [RW-1:0] res,
    input logic [AW-1:0] acc_cur,
    input logic          sel_cur
);
    p_acc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op[1:0] != 2'b11 && !clr) |=> acc_cur == $past(acc_cur));

    p_acc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> acc_cur == '0);

    p_umul_no_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sgn && op == 3'b000 && !sel_cur) |-> !res[RW-1]);

    p_smul_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sgn && op == 3'b000 && !sel_cur) |-> res[RW-1] == res[RW-2]);

    p_hold_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op[2] |=> sel_cur);

    p_comb_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !op[2] |=> !sel_cur);

    p_reset_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (acc_cur == '0 && !sel_cur));
endmodule

bind dyn_muladd dyn_muladd_chk #(.OPW(OPW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .op      (op),
    .sgn     (sgn),
    .res     (res),
    .acc_cur (acc_cur),
    .sel_cur (sel_cur)
);

// File: tb/dyn_muladd_tb_top.sv
module dyn_muladd_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [2:0]  op = 3'b000;
    logic        sgn = 1'b0;
    logic [7:0]  mx = 8'h00;
    logic [7:0]  my = 8'h00;
    logic [15:0] ad = 16'h0000;
    logic [16:0] res;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dyn_muladd dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .op(op), .sgn(sgn),
        .mx(mx), .my(my), .ad(ad), .res(res)
    );

    // {sgn, op, mx, my, ad, expected}
    localparam int VW = 1 + 3 + 8 + 8 + 16 + 17;
    localparam logic [VW-1:0] VEC [9] = '{
        {1'b0, 3'b000, 8'hFF, 8'hFF, 16'h0000, 17'h0FE01},
        {1'b1, 3'b000, 8'hFF, 8'h80, 16'h0000, 17'h00080},
        {1'b1, 3'b000, 8'h80, 8'h7F, 16'h0000, 17'h1C080},
        {1'b0, 3'b001, 8'h12, 8'h34, 16'h1000, 17'h02234},
        {1'b0, 3'b001, 8'hFF, 8'hFF, 16'h0001, 17'h10000},
        {1'b1, 3'b001, 8'h80, 8'h00, 16'h8000, 17'h10000},
        {1'b1, 3'b001, 8'h7F, 8'hFF, 16'h7FFF, 17'h0FFFE},
        {1'b0, 3'b010, 8'h10, 8'h10, 16'hFF00, 17'h10000},
        {1'b1, 3'b010, 8'hFE, 8'h03, 16'h0010, 17'h0000A}
    };

    task automatic check(input string tag, input logic [16:0] exp);
        n_run++;
        if (res !== exp) begin
            n_fail++;
            $display("FAIL %s: res=%h expected=%h", tag, res, exp);
        end
    endtask

    task automatic drive(input logic [2:0] o, input logic s, input logic [7:0] x,
                         input logic [7:0] y, input logic [15:0] a, input logic c);
        @(negedge clk);
        op = o; sgn = s; mx = x; my = y; ad = a; clr = c;
        #2;
    endtask

    initial begin
        #(8 * 50000);
        n_fail++;
        $display("FAIL watchdog: res=%h expected=done", res);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2;
        check("R10 reset comb output", 17'h00000);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: accumulator reads back zero after reset
        drive(3'b011, 1'b0, 8'h00, 8'h00, 16'h0000, 1'b0);
        check("R10 acc zero after reset", 17'h00000);

        // table walk: R1 R2 R3 R4
        for (int i = 0; i < 9; i++) begin
            drive(VEC[i][VW-2 -: 3], VEC[i][VW-1], VEC[i][48:41], VEC[i][40:33],
                  VEC[i][32:17], 1'b0);
            check("R1/R2/R3/R4 vector", VEC[i][16:0]);
        end

        // R5 accumulate 100 three times
        drive(3'b011, 1'b0, 8'd10, 8'd10, 16'h0, 1'b0);
        check("R5 mac step1", 17'd100);
        drive(3'b011, 1'b0, 8'd10, 8'd10, 16'h0, 1'b0);
        check("R5 mac step2", 17'd200);
        drive(3'b011, 1'b0, 8'd10, 8'd10, 16'h0, 1'b0);
        check("R5 mac step3", 17'd300);

        // R6 other modes leave acc alone
        drive(3'b010, 1'b0, 8'd9, 8'd9, 16'h1234, 1'b0);
        drive(3'b001, 1'b1, 8'h80, 8'h00, 16'hFFFF, 1'b0);
        drive(3'b000, 1'b0, 8'd7, 8'd7, 16'h0, 1'b0);
        drive(3'b011, 1'b0, 8'h00, 8'h00, 16'h0, 1'b0);
        check("R6 acc unchanged", 17'd300);

        // R7 clear with accumulate: result uses old acc, acc zero after
        drive(3'b011, 1'b0, 8'd1, 8'd1, 16'h0, 1'b1);
        check("R7 clear cycle old acc", 17'd301);
        drive(3'b011, 1'b0, 8'h00, 8'h00, 16'h0, 1'b0);
        check("R7 acc cleared", 17'd0);

        // R5 unsigned wrap
        drive(3'b011, 1'b0, 8'hFF, 8'hFF, 16'h0, 1'b0);
        check("R5 wrap first", 17'h0FE01);
        drive(3'b011, 1'b0, 8'hFF, 8'hFF, 16'h0, 1'b0);
        check("R5 wrap carry", 17'h1FC02);
        drive(3'b011, 1'b0, 8'h00, 8'h00, 16'h0, 1'b0);
        check("R5 acc wrapped", 17'h0FC02);

        // R5 R2 signed accumulate of negatives
        drive(3'b011, 1'b1, 8'h00, 8'h00, 16'h0, 1'b1);
        drive(3'b011, 1'b1, 8'hFF, 8'h01, 16'h0, 1'b0);
        check("R5 signed mac -1", 17'h1FFFF);
        drive(3'b011, 1'b1, 8'hFF, 8'h01, 16'h0, 1'b0);
        check("R5 signed mac -2", 17'h1FFFE);

        // R9 registered result shown next cycle, R8 after
        drive(3'b100, 1'b0, 8'd3, 8'd4, 16'h0, 1'b0);
        check("R8 comb before hold", 17'd12);
        drive(3'b000, 1'b0, 8'd5, 8'd5, 16'h0, 1'b0);
        check("R9 held result shown", 17'd12);
        drive(3'b000, 1'b0, 8'd5, 8'd5, 16'h0, 1'b0);
        check("R8 comb resumes", 17'd25);

        // R9 back-to-back registered
        drive(3'b100, 1'b0, 8'd2, 8'd2, 16'h0, 1'b0);
        drive(3'b101, 1'b0, 8'd0, 8'd1, 16'h1, 1'b0);
        check("R9 b2b first", 17'd4);
        drive(3'b000, 1'b0, 8'd0, 8'd0, 16'h0, 1'b0);
        check("R9 b2b second", 17'd2);

        // R9 registered accumulate also updates acc
        drive(3'b011, 1'b0, 8'h00, 8'h00, 16'h0, 1'b1);
        drive(3'b111, 1'b0, 8'd7, 8'd1, 16'h0, 1'b0);
        drive(3'b011, 1'b0, 8'h00, 8'h00, 16'h0, 1'b0);
        check("R9 held mac", 17'd7);
        drive(3'b011, 1'b0, 8'h00, 8'h00, 16'h0, 1'b0);
        check("R9 mac acc", 17'd7);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule